// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Seconds Snapshot

This block is an always-running elapsed-time counter. It keeps a seconds count and a millisecond count. Both advance from a 32768 Hz tick enable, which arrives as a single-cycle strobe in the bus clock domain. One millisecond is not a whole number of 32768 Hz periods. A fractional accumulator therefore adds 1000 on every tick and produces one millisecond step each time the sum reaches 32768. It keeps the remainder, so the counter does not drift over time.

Software reads the time through a small register port. Reading the millisecond register also copies the live seconds count into a snapshot register. Both values come from the same clock edge. A following read of the snapshot therefore gives seconds that agree with the milliseconds just read, even if a second boundary passes between the two bus reads. Software combines the two as seconds*1000 + milliseconds. Writing the live seconds register sets the time: it loads the seconds and restarts the sub-second state from zero.

Top module: `ms_rtc`

## Requirements
- R1: After a synchronous reset, the live seconds, the milliseconds, the fractional accumulator and the snapshot are all zero. Every register reads 0.
- R2: After N ticks since the last clear, the total elapsed milliseconds equal floor(N*1000/32768). For example, 32 ticks give 0 ms and 33 ticks give 1 ms.
- R3: The milliseconds count stays within 0..999. On the tick where it wraps from 999 to 0, the seconds count increments in the same cycle.
- R4: A read of offset 0x10 returns the milliseconds. In the same cycle it copies the live seconds into the snapshot.
- R5: The snapshot, read at offset 0x0C, holds its value until the next read of offset 0x10, while the live seconds keep changing.
- R6: A write to offset 0x08 loads the seconds with the write data and clears the milliseconds and the accumulator. If a tick occurs in the same cycle, the write wins and the tick is dropped.
- R7: Writes to offsets 0x0C and 0x10 have no effect.
- R8: Read data is registered and appears one cycle after the read strobe. It is 0 in cycles with no read and for any unmapped offset. Offset 0x08 returns the live seconds.
- R9: Without a tick, the seconds, the milliseconds and the accumulator all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle strobe at 32768 Hz |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The assertions check the following on every cycle:
- the milliseconds stay within range;
- a 999-to-0 wrap carries into the seconds;
- the snapshot captures on a milliseconds read and holds at all other times;
- a seconds write loads the seconds and clears the milliseconds;
- the counters hold when no tick arrives;
- the read data idles at zero.

The long-run fractional rate can only be shown by the bench's scenarios, which run the full 32768-tick second. The same applies to the tick dropped by a write in the same cycle, to writes to read-only offsets having no effect, and to the agreement between a snapshot and the milliseconds read before it across a second boundary. The bench checks these against a model that works from the tick count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 8;
  // Register offsets: software depends on these positions.
  localparam logic [ADDR_W-1:0] OFS_SEC_LIVE = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SEC_SNAP = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MSEC     = 8'h10;
endpackage

// File: rtl/rtc_frac_div.sv
// Fractional divider: emits one step per millisecond from a slow tick.
module rtc_frac_div #(
  parameter int TICK_HZ = 32768,
  parameter int STEPS_HZ = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic step
);
  localparam int ACC_W = $clog2(TICK_HZ);
  localparam int SUM_W = $clog2(TICK_HZ + STEPS_HZ) + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;
  logic             reach;

  always_comb begin
    sum   = SUM_W'(acc_q) + SUM_W'(STEPS_HZ);
    reach = tick && (sum >= SUM_W'(TICK_HZ));
    step  = reach && !clear;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
    end else if (tick) begin
      if (reach) acc_q <= ACC_W'(sum - SUM_W'(TICK_HZ));
      else       acc_q <= ACC_W'(sum);
    end
  end
endmodule

// File: rtl/rtc_time_count.sv
// Seconds and milliseconds counters with load.
module rtc_time_count #(
  parameter int SEC_W = 32,
  parameter int MS_PER_S = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  input  logic             step,
  output logic [SEC_W-1:0] sec_q,
  output logic [$clog2(MS_PER_S)-1:0] ms_q
);
  localparam int MS_W = $clog2(MS_PER_S);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_S - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      ms_q  <= '0;
    end else if (load) begin
      sec_q <= load_val;
      ms_q  <= '0;
    end else if (step) begin
      if (ms_q == MS_LAST) begin
        ms_q  <= '0;
        sec_q <= sec_q + 1'b1;
      end else begin
        ms_q <= ms_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_bus_regs.sv
// Register port: decode, seconds snapshot, registered read data.
module rtc_bus_regs #(
  parameter int DATA_W = 32,
  parameter int SEC_W = 32,
  parameter int MS_W = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd,
  input  logic                       wr,
  input  logic [rtc_pkg::ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [SEC_W-1:0]           sec_q,
  input  logic [MS_W-1:0]            ms_q,
  output logic                       sec_load,
  output logic [SEC_W-1:0]           load_val,
  output logic                       ms_rd,
  output logic [SEC_W-1:0]           snap_q,
  output logic [DATA_W-1:0]          rdata
);
  import rtc_pkg::*;

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    sec_load = wr && (addr == OFS_SEC_LIVE);
    load_val = SEC_W'(wdata);
    ms_rd    = rd && (addr == OFS_MSEC);
    rd_mux   = '0;
    if (rd) begin
      case (addr)
        OFS_SEC_LIVE: rd_mux = DATA_W'(sec_q);
        OFS_SEC_SNAP: rd_mux = DATA_W'(snap_q);
        OFS_MSEC:     rd_mux = DATA_W'(ms_q);
        default:      rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      rdata  <= '0;
    end else begin
      rdata <= rd_mux;
      if (ms_rd) snap_q <= sec_q;
    end
  end
endmodule

// File: rtl/ms_rtc.sv
module ms_rtc #(
  parameter int TICK_HZ = 32768,
  parameter int MS_PER_S = 1000,
  parameter int SEC_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick_32k,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  input  logic [rtc_pkg::ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata
);
  localparam int MS_W = $clog2(MS_PER_S);

  logic             ms_step;
  logic             sec_load;
  logic             ms_rd;
  logic [SEC_W-1:0] load_val;
  logic [SEC_W-1:0] sec_q;
  logic [SEC_W-1:0] snap_q;
  logic [MS_W-1:0]  ms_q;

  rtc_frac_div #(.TICK_HZ(TICK_HZ), .STEPS_HZ(MS_PER_S)) u_div (
    .clk(clk), .rst(rst), .clear(sec_load), .tick(tick_32k), .step(ms_step)
  );

  rtc_time_count #(.SEC_W(SEC_W), .MS_PER_S(MS_PER_S)) u_cnt (
    .clk(clk), .rst(rst), .load(sec_load), .load_val(load_val),
    .step(ms_step), .sec_q(sec_q), .ms_q(ms_q)
  );

  rtc_bus_regs #(.DATA_W(DATA_W), .SEC_W(SEC_W), .MS_W(MS_W)) u_regs (
    .clk(clk), .rst(rst), .rd(bus_rd), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .sec_q(sec_q), .ms_q(ms_q), .sec_load(sec_load),
    .load_val(load_val), .ms_rd(ms_rd), .snap_q(snap_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/ms_rtc_chk.sv
module ms_rtc_chk #(
  parameter int SEC_W = 32,
  parameter int MS_W = 10,
  parameter int DATA_W = 32,
  parameter int MS_PER_S = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_32k,
  input logic              bus_rd,
  input logic              sec_load,
  input logic              ms_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [SEC_W-1:0]  sec_q,
  input logic [SEC_W-1:0]  snap_q,
  input logic [MS_W-1:0]   ms_q,
  input logic [DATA_W-1:0] bus_rdata
);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_S - 1);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (bus_rdata == '0 && sec_q == '0 && ms_q == '0 && snap_q == '0)); // R1
  AST_MS_RANGE: assert property (@(posedge clk) disable iff (rst) ms_q <= MS_LAST); // R3
  AST_WRAP_CARRY: assert property (@(posedge clk) disable iff (rst) (ms_q == '0 && $past(ms_q) == MS_LAST && !$past(sec_load)) |-> sec_q == $past(sec_q) + 1'b1); // R3
  AST_SNAP_LATCH: assert property (@(posedge clk) disable iff (rst) ms_rd |=> snap_q == $past(sec_q)); // R4
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst) !ms_rd |=> $stable(snap_q)); // R5
  AST_SEC_LOAD: assert property (@(posedge clk) disable iff (rst) sec_load |=> (sec_q == $past(SEC_W'(bus_wdata)) && ms_q == '0)); // R6
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst) !bus_rd |=> bus_rdata == '0); // R8
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst) (!tick_32k && !sec_load) |=> ($stable(ms_q) && $stable(sec_q))); // R9
endmodule

bind ms_rtc ms_rtc_chk #(.SEC_W(SEC_W), .MS_W(MS_W), .DATA_W(DATA_W), .MS_PER_S(MS_PER_S)) u_chk (
  .clk(clk), .rst(rst), .tick_32k(tick_32k), .bus_rd(bus_rd), .sec_load(sec_load),
  .ms_rd(ms_rd), .bus_wdata(bus_wdata), .sec_q(sec_q), .snap_q(snap_q),
  .ms_q(ms_q), .bus_rdata(bus_rdata)
);

// File: tb/ms_rtc_test.sv
`timescale 1ns/1ps
module ms_rtc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  ms_rtc uut (
    .clk(clk), .rst(rst), .tick_32k(tick), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  // Behavioural reference: time derived from tick count since last clear.
  longint      ticks = 0;
  logic [31:0] base = '0;
  logic [31:0] shad = '0;
  logic [31:0] exp_rd = '0;

  function automatic logic [31:0] m_sec();
    return 32'(longint'(base) + ((ticks * 1000) / 32768) / 1000);
  endfunction
  function automatic logic [31:0] m_ms();
    return 32'(((ticks * 1000) / 32768) % 1000);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ticks = 0; base = '0; shad = '0; exp_rd = '0;
    end else begin
      exp_rd = '0;
      if (bus_rd) begin
        case (bus_addr)
          8'h08: exp_rd = m_sec();
          8'h0C: exp_rd = shad;
          8'h10: begin exp_rd = m_ms(); shad = m_sec(); end
          default: exp_rd = '0;
        endcase
      end
      if (bus_wr && bus_addr == 8'h08) begin
        base = bus_wdata; ticks = 0;
      end else if (tick) begin
        ticks++;
      end
    end
    #2;
    checks++;
    if (bus_rdata !== exp_rd) begin
      errors++;
      $display("FAIL R8 per-cycle model: actual %0d expected %0d", bus_rdata, exp_rd);
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    chk(bus_rdata, e, tag);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input logic t);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = t;
    @(negedge clk); bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd_chk(8'h08, 0, "R1 seconds after reset");
    rd_chk(8'h10, 0, "R1 ms after reset");
    rd_chk(8'h0C, 0, "R1 snapshot after reset");

    wr_reg(8'h08, 100, 1'b0);
    rd_chk(8'h08, 100, "R6 seconds loaded");
    ticks_n(32);
    rd_chk(8'h10, 0, "R2 32 ticks below one ms");
    ticks_n(1);
    rd_chk(8'h10, 1, "R2 33 ticks reach one ms");

    wr_reg(8'h08, 7, 1'b0);
    ticks_n(32767);
    rd_chk(8'h10, 999, "R2 last ms of second");
    rd_chk(8'h08, 7, "R3 seconds before wrap");
    ticks_n(1);
    rd_chk(8'h10, 0, "R3 ms wraps to zero");
    rd_chk(8'h08, 8, "R3 seconds carry");
    rd_chk(8'h0C, 8, "R4 snapshot from ms read");

    wr_reg(8'h08, 50, 1'b0);
    rd_chk(8'h0C, 8, "R5 snapshot holds after load");
    rd_chk(8'h08, 50, "R5 live seconds moved");
    ticks_n(33);
    rd_chk(8'h10, 1, "R4 ms read value");
    rd_chk(8'h0C, 50, "R4 snapshot recaptured");

    wr_reg(8'h08, 20, 1'b1);
    ticks_n(32);
    rd_chk(8'h10, 0, "R6 same-cycle tick dropped");

    wr_reg(8'h10, 5, 1'b0);
    wr_reg(8'h0C, 99, 1'b0);
    rd_chk(8'h10, 0, "R7 ms write ignored");
    rd_chk(8'h0C, 20, "R7 snapshot write ignored");
    rd_chk(8'h08, 20, "R7 seconds unchanged");

    @(negedge clk);
    chk(bus_rdata, 0, "R8 idle read data");
    rd_chk(8'h14, 0, "R8 unmapped offset");

    repeat (50) @(negedge clk);
    rd_chk(8'h10, 0, "R9 ms holds without tick");
    ticks_n(1);
    rd_chk(8'h10, 1, "R9 accumulator kept while idle");

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule